// File: doc/BRIEF.md
# Bit-Slice Arithmetic, Logic and Shift Unit

This block is a purely combinational datapath unit of parameterised width, four bits by default. It is built from identical one-bit stages. Each stage holds three parts. The first is an adder cell that sums an operand bit, a selectable second term and the incoming carry. The second is a logic cell that forms one of four bitwise functions. The third is a four-way output selector. That selector passes on one of four values: the sum, the logic value, the operand bit one place to the left, or the operand bit one place to the right. With this arrangement a single four-bit operation code covers the arithmetic operations, the bitwise operations and one-place shifts in either direction.

A surrounding datapath presents two operands, a carry input, the operation code and two serial fill bits. It takes the result, the carry out of the most significant stage and a signed overflow flag in the same cycle. The carry chain ripples from stage to stage. The overflow flag compares the carry entering the top stage with the carry leaving it. Both flags read zero whenever the operation is not arithmetic.

Top module: `bitslice_alu`

## Requirements
- R1: With op = 4'b0000, the result is f = a + b + cin modulo 2^W, and cout is the carry out of bit W-1.
- R2: With op = 4'b0001, the result is f = a + ~b + cin, which is a - b - 1 when cin = 0 and a - b when cin = 1. cout is the carry out of that sum.
- R3: With op = 4'b0010, the result is f = a + cin, which either passes a through or increments it. cout is the carry out.
- R4: With op = 4'b0011, the result is f = a + (2^W - 1) + cin, which decrements a when cin = 0 and passes a through when cin = 1. cout is the carry out.
- R5: With op[3:2] = 2'b00, ovf is 1 exactly when the two's-complement sum of a, the selected second term and cin lies outside the signed W-bit range.
- R6: With op[3:2] = 2'b01, f is chosen by op[1:0]: 00 gives a AND b, 01 gives a OR b, 10 gives a XOR b, and 11 gives NOT a. cin has no effect.
- R7: With op[3:2] = 2'b10, f is a shifted right by one place: f[i] = a[i+1], and f[W-1] takes fill_r. op[1:0], b and cin have no effect.
- R8: With op[3:2] = 2'b11, f is a shifted left by one place: f[i] = a[i-1], and f[0] takes fill_l. op[1:0], b and cin have no effect.
- R9: Whenever op[3:2] is not 2'b00, cout and ovf are both 0.
- R10: The fill inputs fill_r and fill_l have no effect on any output unless a shift is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand; also the value that is shifted |
| b_i | input | W | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| op_i | input | 4 | Operation code: [3:2] picks the part, [1:0] picks the variant |
| fill_r_i | input | 1 | Bit entering the MSB on a right shift |
| fill_l_i | input | 1 | Bit entering the LSB on a left shift |
| f_o | output | W | Result |
| cout_o | output | 1 | Carry out of the MSB; arithmetic only |
| ovf_o | output | 1 | Signed overflow; arithmetic only |

## Verification
Two functions can land in the same cycle. One is the carry ripple that feeds the overflow and carry flags. The other is the suppression of those flags in the non-arithmetic parts. Every stage still computes a sum while a logic or shift result is being selected. The bench therefore applies every combination of operands, carry, operation code and fill bits, and sweeps carry-producing operands through the logic and shift codes. A behavioural integer model judges each combination: the flags must follow the signed range of the sum in arithmetic codes and must read zero in all others. The fill bits change under every non-shift code, so any leak of them into the result shows up.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;

    typedef enum logic [1:0] {
        PART_ARITH = 2'b00,
        PART_LOGIC = 2'b01,
        PART_SHR   = 2'b10,
        PART_SHL   = 2'b11
    } part_e;

    typedef enum logic [1:0] {
        YTERM_B    = 2'b00,
        YTERM_NB   = 2'b01,
        YTERM_ZERO = 2'b10,
        YTERM_ONE  = 2'b11
    } yterm_e;

    typedef enum logic [1:0] {
        LOGOP_AND  = 2'b00,
        LOGOP_OR   = 2'b01,
        LOGOP_XOR  = 2'b10,
        LOGOP_NOTA = 2'b11
    } logop_e;

    typedef struct packed {
        logic sum;
        logic carry;
    } addbit_t;

endpackage

// File: rtl/bsalu_arith_bit.sv
module bsalu_arith_bit
    import bsalu_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       cin_i,
    input  logic [1:0] ysel_i,
    output logic       sum_o,
    output logic       cout_o
);

    logic    y_d;
    addbit_t res_d;

    // Second addend chosen per bit
    always_comb begin
        unique case (yterm_e'(ysel_i))
            YTERM_B:    y_d = b_i;
            YTERM_NB:   y_d = ~b_i;
            YTERM_ZERO: y_d = 1'b0;
            default:    y_d = 1'b1;
        endcase
    end

    // Full adder cell
    always_comb begin
        res_d.sum   = a_i ^ y_d ^ cin_i;
        res_d.carry = (a_i & y_d) | (cin_i & (a_i ^ y_d));
    end

    assign sum_o  = res_d.sum;
    assign cout_o = res_d.carry;

endmodule

// File: rtl/bsalu_logic_bit.sv
module bsalu_logic_bit
    import bsalu_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic [1:0] fsel_i,
    output logic       e_o
);

    logic e_d;

    always_comb begin
        unique case (logop_e'(fsel_i))
            LOGOP_AND: e_d = a_i & b_i;
            LOGOP_OR:  e_d = a_i | b_i;
            LOGOP_XOR: e_d = a_i ^ b_i;
            default:   e_d = ~a_i;
        endcase
    end

    assign e_o = e_d;

endmodule

// File: rtl/bsalu_slice.sv
module bsalu_slice
    import bsalu_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       a_left_i,   // neighbour above, or right-shift fill
    input  logic       a_right_i,  // neighbour below, or left-shift fill
    input  logic       cin_i,
    input  logic [3:0] op_i,
    output logic       f_o,
    output logic       cout_o
);

    logic sum_d;
    logic log_d;
    logic f_d;

    bsalu_arith_bit u_arith (
        .a_i    (a_i),
        .b_i    (b_i),
        .cin_i  (cin_i),
        .ysel_i (op_i[1:0]),
        .sum_o  (sum_d),
        .cout_o (cout_o)
    );

    bsalu_logic_bit u_logic (
        .a_i    (a_i),
        .b_i    (b_i),
        .fsel_i (op_i[1:0]),
        .e_o    (log_d)
    );

    // Output selector of the stage
    always_comb begin
        unique case (part_e'(op_i[3:2]))
            PART_ARITH: f_d = sum_d;
            PART_LOGIC: f_d = log_d;
            PART_SHR:   f_d = a_left_i;
            default:    f_d = a_right_i;
        endcase
    end

    assign f_o = f_d;

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import bsalu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic [3:0]   op_i,
    input  logic         fill_r_i,
    input  logic         fill_l_i,
    output logic [W-1:0] f_o,
    output logic         cout_o,
    output logic         ovf_o
);

    localparam int MSB = W - 1;

    logic [W-1:0] f_d;
    logic         arith_d;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic cin_d;
        logic cout_d;
        logic left_d;
        logic right_d;

        if (i == 0) begin : g_lsb
            assign cin_d   = cin_i;
            assign right_d = fill_l_i;
        end else begin : g_inner
            assign cin_d   = g_bit[i-1].cout_d;
            assign right_d = a_i[i-1];
        end

        if (i == MSB) begin : g_msb
            assign left_d = fill_r_i;
        end else begin : g_below
            assign left_d = a_i[i+1];
        end

        bsalu_slice u_slice (
            .a_i       (a_i[i]),
            .b_i       (b_i[i]),
            .a_left_i  (left_d),
            .a_right_i (right_d),
            .cin_i     (cin_d),
            .op_i      (op_i),
            .f_o       (f_d[i]),
            .cout_o    (cout_d)
        );
    end

    assign arith_d = (part_e'(op_i[3:2]) == PART_ARITH);

    assign f_o    = f_d;
    assign cout_o = arith_d & g_bit[MSB].cout_d;
    assign ovf_o  = arith_d & (g_bit[MSB].cout_d ^ g_bit[MSB].cin_d);

endmodule

// File: rtl/bitslice_alu_chk.sv
module bitslice_alu_chk #(
    parameter int W = 4
) (
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic         cin_i,
    input logic [3:0]   op_i,
    input logic         fill_r_i,
    input logic         fill_l_i,
    input logic [W-1:0] f_o,
    input logic         cout_o,
    input logic         ovf_o
);

    logic [W-1:0] y_c;
    logic [W:0]   wide_c;
    logic [W-1:0] lg_c;

    always_comb begin
        case (op_i[1:0])
            2'b00:   y_c = b_i;
            2'b01:   y_c = ~b_i;
            2'b10:   y_c = '0;
            default: y_c = '1;
        endcase
        wide_c = {1'b0, a_i} + {1'b0, y_c} + {{W{1'b0}}, cin_i};
        case (op_i[1:0])
            2'b00:   lg_c = a_i & b_i;
            2'b01:   lg_c = a_i | b_i;
            2'b10:   lg_c = a_i ^ b_i;
            default: lg_c = ~a_i;
        endcase

        if (op_i[3:2] == 2'b00) begin
            p_sum_r1: assert ({cout_o, f_o} == wide_c)
                else $error("arith sum/carry mismatch (R1..R4)");
            p_no_overflow_r5: assert (ovf_o ==
                ((a_i[W-1] == y_c[W-1]) && (f_o[W-1] != a_i[W-1])))
                else $error("signed overflow flag wrong");
        end
        if (op_i[3:2] == 2'b01) begin
            p_logic_r6: assert (f_o == lg_c)
                else $error("logic result wrong");
        end
        if (op_i[3:2] == 2'b10) begin
            p_shr_r7: assert (f_o == {fill_r_i, a_i[W-1:1]})
                else $error("right shift wrong");
        end
        if (op_i[3:2] == 2'b11) begin
            p_shl_r8: assert (f_o == {a_i[W-2:0], fill_l_i})
                else $error("left shift wrong");
        end
        if (op_i[3:2] != 2'b00) begin
            p_flags_quiet_r9: assert (!cout_o && !ovf_o)
                else $error("flags active outside arithmetic");
        end
    end

endmodule

bind bitslice_alu bitslice_alu_chk #(.W(W)) u_chk (
    .a_i      (a_i),
    .b_i      (b_i),
    .cin_i    (cin_i),
    .op_i     (op_i),
    .fill_r_i (fill_r_i),
    .fill_l_i (fill_l_i),
    .f_o      (f_o),
    .cout_o   (cout_o),
    .ovf_o    (ovf_o)
);

// File: tb/bitslice_alu_bench.sv
module bitslice_alu_bench;

    localparam int W          = 4;
    localparam int CLK_PERIOD = 10;
    localparam int MASK       = (1 << W) - 1;
    localparam int LIMIT_CYC  = 200000;

    logic         clk = 1'b0;
    logic [W-1:0] a_r = '0;
    logic [W-1:0] b_r = '0;
    logic         cin_r = 1'b0;
    logic [3:0]   op_r = '0;
    logic         fr_r = 1'b0;
    logic         fl_r = 1'b0;
    logic [W-1:0] f_w;
    logic         cout_w;
    logic         ovf_w;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bitslice_alu #(.W(W)) u_bitslice_alu (
        .a_i      (a_r),
        .b_i      (b_r),
        .cin_i    (cin_r),
        .op_i     (op_r),
        .fill_r_i (fr_r),
        .fill_l_i (fl_r),
        .f_o      (f_w),
        .cout_o   (cout_w),
        .ovf_o    (ovf_w)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s op=%b a=%0d b=%0d cin=%0d: actual %0d expected %0d",
                     req, op_r, a_r, b_r, cin_r, act, exp);
        end
    endtask

    // Behavioural reference from the requirements
    task automatic model(input int a, input int b, input int cin, input int op,
                         input int fr, input int fl,
                         output int f, output int co, output int v);
        int y, s, sa, sy;
        f = 0; co = 0; v = 0;
        case (op >> 2)
            0: begin
                case (op & 3)
                    0:       y = b;
                    1:       y = (~b) & MASK;
                    2:       y = 0;
                    default: y = MASK;
                endcase
                s  = a + y + cin;
                f  = s & MASK;
                co = (s >> W) & 1;
                sa = (a >= (1 << (W - 1))) ? a - (1 << W) : a;
                sy = (y >= (1 << (W - 1))) ? y - (1 << W) : y;
                s  = sa + sy + cin;
                v  = (s > (1 << (W - 1)) - 1 || s < -(1 << (W - 1))) ? 1 : 0;
            end
            1: begin
                case (op & 3)
                    0:       f = a & b;
                    1:       f = a | b;
                    2:       f = a ^ b;
                    default: f = (~a) & MASK;
                endcase
            end
            2:       f = (a >> 1) | (fr << (W - 1));
            default: f = ((a << 1) & MASK) | fl;
        endcase
    endtask

    function automatic string ftag(input int op);
        string t;
        case (op)
            0: t = "R1";
            1: t = "R2";
            2: t = "R3";
            3: t = "R4";
            default: t = ((op >> 2) == 1) ? "R6" : ((op >> 2) == 2) ? "R7" : "R8";
        endcase
        if (op < 8) t = {t, " R10"};
        return t;
    endfunction

    task automatic apply_and_check(input int a, input int b, input int cin,
                                   input int op, input int fr, input int fl);
        int ef, ec, ev;
        @(posedge clk);
        a_r   = W'(a);
        b_r   = W'(b);
        cin_r = cin[0];
        op_r  = op[3:0];
        fr_r  = fr[0];
        fl_r  = fl[0];
        @(negedge clk);
        model(a, b, cin, op, fr, fl, ef, ec, ev);
        check(ftag(op), int'(f_w), ef);
        check((op < 4) ? ftag(op) : "R9", int'(cout_w), ec);
        check((op < 4) ? "R5" : "R9", int'(ovf_w), ev);
    endtask

    initial begin
        @(negedge clk);
        // Idle state with all inputs low: add of zeros
        check("R1 idle", int'(f_w), 0);
        check("R1 idle", int'(cout_w), 0);
        check("R5 idle", int'(ovf_w), 0);

        // Directed corners
        apply_and_check(7, 1, 0, 4'b0000, 0, 0);   // R5 positive overflow
        apply_and_check(8, 1, 1, 4'b0001, 0, 0);   // R2: -8 - 1 overflows
        apply_and_check(15, 0, 1, 4'b0010, 1, 1);  // R3 increment wraps, carry out
        apply_and_check(0, 0, 0, 4'b0011, 1, 1);   // R4 decrement from zero
        apply_and_check(15, 15, 1, 4'b0100, 1, 1); // R9 flags quiet in logic
        apply_and_check(9, 6, 1, 4'b1011, 1, 0);   // R7 fill into MSB
        apply_and_check(9, 6, 1, 4'b1100, 0, 1);   // R8 fill into LSB

        // Exhaustive sweep over every input combination
        for (int op = 0; op < 16; op++)
            for (int a = 0; a <= MASK; a++)
                for (int b = 0; b <= MASK; b++)
                    for (int c = 0; c < 2; c++)
                        for (int fz = 0; fz < 4; fz++)
                            apply_and_check(a, b, c, op, fz & 1, fz >> 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (LIMIT_CYC) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule